// File: doc/BRIEF.md
# Address-Value Delta Load Predictor

This block guesses the value that a pointer-producing load will return when the load misses in the second-level cache while the core runs ahead speculatively. For many such loads, the effective address minus the loaded value stays constant from one execution to the next. That happens, for example, when linked nodes are laid out with a fixed stride, or when a node and its string are allocated back to back. The block learns this difference per load PC. When it is confident, it predicts the loaded value as the lookup address minus the learned difference.

The training stream carries retiring loads in normal mode: PC, effective address and loaded value. Training is always accepted, so `trn_ready` is tied high. Loads whose difference falls outside a symmetric window of ±`MAX_DELTA` are dropped, because they are probably not pointers. The lookup stream carries the PC and effective address of a load that missed during runahead. Each accepted lookup produces exactly one response, carrying a hit flag and a value.

A lookup is accepted when `lkp_valid && lkp_ready`. `lkp_ready` is high whenever the response register is empty, or when its content is taken in the same cycle (`rsp_ready`). A response that is not taken holds its value unchanged until it is taken. A wrong prediction needs no repair, because runahead results are thrown away.

Top module: `avd_predictor`

## Requirements
- R1: After reset, `rsp_valid` is 0, `lkp_ready` and `trn_ready` are 1, and the table is empty, so every lookup misses.
- R2: A training load's difference is address minus data, taken as a signed value. Differences from -MAX_DELTA to +MAX_DELTA inclusive are trained. Any other training load changes nothing, including the replacement order.
- R3: A training load whose PC is not in its set allocates an entry with confidence 0. A lookup after that single training misses.
- R4: A training load whose PC matches and whose difference equals the stored one raises a 2-bit confidence that saturates at 3. A lookup predicts only when the confidence is 2 or more, which is after the third identical training.
- R5: A training load whose PC matches but whose difference differs replaces the stored difference and clears the confidence to 0.
- R6: A predicting lookup returns `rsp_hit`=1 and `rsp_value` = lookup address minus the sign-extended stored difference, modulo 2^ADDR_W.
- R7: The set is `pc[PC_LSB +: log2(SETS)]` and the tag is the full PC. A training miss fills the lowest-numbered free way, or else the least recently trained way. Lookups do not affect that order, and PCs in different sets never evict each other.
- R8: A lookup is accepted when `lkp_valid && lkp_ready`, with `lkp_ready = !rsp_valid || rsp_ready`. Its response appears the cycle after acceptance. While `rsp_valid && !rsp_ready`, the response holds and `lkp_ready` is 0.
- R9: When a training load and a lookup are accepted in the same cycle, the lookup sees the table as it was before that training.
- R10: A lookup that does not predict returns `rsp_hit`=0 and `rsp_value`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trn_valid | input | 1 | Training load present |
| trn_ready | output | 1 | Training accepted (always 1) |
| trn_pc | input | PC_W | Training load PC |
| trn_addr | input | ADDR_W | Training load effective address |
| trn_data | input | ADDR_W | Training load value |
| lkp_valid | input | 1 | Lookup request present |
| lkp_ready | output | 1 | Lookup can be accepted |
| lkp_pc | input | PC_W | Lookup load PC |
| lkp_addr | input | ADDR_W | Lookup effective address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Prediction is valid |
| rsp_value | output | ADDR_W | Predicted load value, or 0 |

## Verification
Training sequences of one, two and three identical differences show where the confidence threshold lies. A change of difference after saturation shows that the counter is cleared rather than decremented. Differences exactly at ±MAX_DELTA and one beyond separate an inclusive window from an exclusive one, and an out-of-window load sent to an already confident PC shows that dropped loads leave the entry alone. Filling one set, retraining an old entry, and issuing lookups in an order that would disturb a lookup-driven replacement order tell true least-recently-trained eviction apart from FIFO and from lookup-refreshed orders. A training load and a lookup to the same PC in one cycle, a stalled response, and a prediction that wraps below zero cover the ordering, the handshake and the arithmetic.

// File: rtl/avd_pkg.sv
package avd_pkg;
  localparam int CONF_W = 2;
  typedef logic [CONF_W-1:0] conf_t;
  localparam conf_t CONF_TOP     = '1;
  localparam conf_t CONF_PREDICT = conf_t'(2);

  function automatic conf_t conf_bump(input conf_t c);
    return (c == CONF_TOP) ? c : c + conf_t'(1);
  endfunction
endpackage

// File: rtl/avd_delta_filter.sv
module avd_delta_filter #(
  parameter int ADDR_W    = 32,
  parameter int DELTA_W   = 12,
  parameter int MAX_DELTA = 1024
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [ADDR_W-1:0]         data,
  output logic signed [DELTA_W-1:0] delta,
  output logic                      in_range
);
  localparam logic signed [ADDR_W-1:0] LIM = ADDR_W'(MAX_DELTA);

  logic signed [ADDR_W-1:0] diff;

  always_comb begin
    diff     = $signed(addr - data);
    in_range = (diff <= LIM) && (diff >= -LIM);
    delta    = diff[DELTA_W-1:0];
  end
endmodule

// File: rtl/avd_way_match.sv
module avd_way_match #(
  parameter int WAYS = 4,
  parameter int PC_W = 32,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  vld,
  input  logic [PC_W-1:0]  tags [WAYS],
  input  logic [PC_W-1:0]  pc,
  output logic             hit,
  output logic [WAYS-1:0]  hit_oh,
  output logic [WAY_W-1:0] hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_oh[w] = vld[w] && (tags[w] == pc);
  end

  always_comb begin
    hit     = |hit_oh;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_oh[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/avd_lru_set.sv
module avd_lru_set #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] oldest_way
);
  logic [WAY_W-1:0] age_q [WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WAYS; i++) age_q[i] <= WAY_W'(i);
    end else if (touch) begin
      for (int i = 0; i < WAYS; i++) begin
        if (WAY_W'(i) == touch_way)           age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_way]) age_q[i] <= age_q[i] + WAY_W'(1);
      end
    end
  end

  always_comb begin
    oldest_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (age_q[i] == WAY_W'(WAYS-1)) oldest_way = WAY_W'(i);
    end
  end
endmodule

// File: rtl/avd_predictor.sv
module avd_predictor #(
  parameter int PC_W      = 32,
  parameter int ADDR_W    = 32,
  parameter int SETS      = 4,
  parameter int WAYS      = 4,
  parameter int PC_LSB    = 2,
  parameter int MAX_DELTA = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trn_valid,
  output logic              trn_ready,
  input  logic [PC_W-1:0]   trn_pc,
  input  logic [ADDR_W-1:0] trn_addr,
  input  logic [ADDR_W-1:0] trn_data,
  input  logic              lkp_valid,
  output logic              lkp_ready,
  input  logic [PC_W-1:0]   lkp_pc,
  input  logic [ADDR_W-1:0] lkp_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [ADDR_W-1:0] rsp_value
);
  import avd_pkg::*;

  localparam int IDX_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int ENTRIES = SETS * WAYS;
  localparam int DELTA_W = $clog2(MAX_DELTA + 1) + 1;

  // table storage, entry index = {set, way}
  logic [ENTRIES-1:0]         vld_q;
  logic [PC_W-1:0]            tag_q  [ENTRIES];
  logic signed [DELTA_W-1:0]  dlt_q  [ENTRIES];
  conf_t                      conf_q [ENTRIES];

  // ---------------- training side ----------------
  logic [IDX_W-1:0]          tr_set;
  logic signed [DELTA_W-1:0] tr_delta;
  logic                      trn_in_range;
  logic                      tr_do;
  logic [WAYS-1:0]           tr_vld;
  logic [PC_W-1:0]           tr_tags [WAYS];
  logic                      tr_hit;
  logic [WAYS-1:0]           tr_hit_oh;
  logic [WAY_W-1:0]          tr_hit_way;
  logic [WAY_W-1:0]          tr_victim;
  logic [WAY_W-1:0]          tr_way;
  logic [WAY_W-1:0]          set_oldest [SETS];
  logic                      victim_free;

  assign trn_ready = 1'b1;
  assign tr_set    = trn_pc[PC_LSB +: IDX_W];

  avd_delta_filter #(.ADDR_W(ADDR_W), .DELTA_W(DELTA_W), .MAX_DELTA(MAX_DELTA)) u_filter (
    .addr     (trn_addr),
    .data     (trn_data),
    .delta    (tr_delta),
    .in_range (trn_in_range)
  );

  assign tr_do = trn_valid && trn_in_range;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      tr_vld[w]  = vld_q[{tr_set, WAY_W'(w)}];
      tr_tags[w] = tag_q[{tr_set, WAY_W'(w)}];
    end
  end

  avd_way_match #(.WAYS(WAYS), .PC_W(PC_W)) u_tr_match (
    .vld     (tr_vld),
    .tags    (tr_tags),
    .pc      (trn_pc),
    .hit     (tr_hit),
    .hit_oh  (tr_hit_oh),
    .hit_way (tr_hit_way)
  );

  // free way first (lowest index), otherwise least recently trained
  always_comb begin
    tr_victim   = set_oldest[tr_set];
    victim_free = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!tr_vld[w] && !victim_free) begin
        tr_victim   = WAY_W'(w);
        victim_free = 1'b1;
      end
    end
    tr_way = tr_hit ? tr_hit_way : tr_victim;
  end

  for (genvar s = 0; s < SETS; s++) begin : g_lru
    avd_lru_set #(.WAYS(WAYS)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch      (tr_do && (tr_set == IDX_W'(s))),
      .touch_way  (tr_way),
      .oldest_way (set_oldest[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (tr_do) begin
      if (tr_hit) begin
        if (dlt_q[{tr_set, tr_way}] == tr_delta) begin
          conf_q[{tr_set, tr_way}] <= conf_bump(conf_q[{tr_set, tr_way}]);
        end else begin
          dlt_q[{tr_set, tr_way}]  <= tr_delta;
          conf_q[{tr_set, tr_way}] <= '0;
        end
      end else begin
        vld_q[{tr_set, tr_way}]  <= 1'b1;
        tag_q[{tr_set, tr_way}]  <= trn_pc;
        dlt_q[{tr_set, tr_way}]  <= tr_delta;
        conf_q[{tr_set, tr_way}] <= '0;
      end
    end
  end

  // ---------------- lookup side ----------------
  logic [IDX_W-1:0]          lk_set;
  logic [WAYS-1:0]           lk_vld;
  logic [PC_W-1:0]           lk_tags [WAYS];
  logic                      lk_hit;
  logic [WAYS-1:0]           lk_hit_oh;
  logic [WAY_W-1:0]          lk_way;
  logic signed [DELTA_W-1:0] lk_delta;
  logic                      lk_predict;
  logic [ADDR_W-1:0]         lk_value;
  logic                      lkp_fire;

  assign lk_set = lkp_pc[PC_LSB +: IDX_W];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_vld[w]  = vld_q[{lk_set, WAY_W'(w)}];
      lk_tags[w] = tag_q[{lk_set, WAY_W'(w)}];
    end
  end

  avd_way_match #(.WAYS(WAYS), .PC_W(PC_W)) u_lk_match (
    .vld     (lk_vld),
    .tags    (lk_tags),
    .pc      (lkp_pc),
    .hit     (lk_hit),
    .hit_oh  (lk_hit_oh),
    .hit_way (lk_way)
  );

  always_comb begin
    lk_delta   = dlt_q[{lk_set, lk_way}];
    lk_predict = lk_hit && (conf_q[{lk_set, lk_way}] >= CONF_PREDICT);
    lk_value   = lkp_addr - {{(ADDR_W-DELTA_W){lk_delta[DELTA_W-1]}}, lk_delta};
  end

  assign lkp_ready = !rsp_valid || rsp_ready;
  assign lkp_fire  = lkp_valid && lkp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_value <= '0;
    end else if (lkp_fire) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= lk_predict;
      rsp_value <= lk_predict ? lk_value : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/avd_predictor_chk.sv
module avd_predictor_chk #(
  parameter int WAYS    = 4,
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lkp_valid,
  input logic              lkp_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic [ADDR_W-1:0] rsp_value,
  input logic              trn_valid,
  input logic              trn_in_range,
  input logic [ENTRIES-1:0] vld_q,
  input logic [WAYS-1:0]   lk_hit_oh,
  input logic [WAYS-1:0]   tr_hit_oh
);
  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_value) && $stable(rsp_hit));

  // R8
  lkp_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid && lkp_ready |=> rsp_valid);

  // R7
  tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_oh) && $onehot0(tr_hit_oh));

  // R2
  filter_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trn_valid && !trn_in_range |=> $stable(vld_q));

  // R10
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_value == '0);
endmodule

bind avd_predictor avd_predictor_chk #(.WAYS(WAYS), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lkp_valid    (lkp_valid),
  .lkp_ready    (lkp_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_hit      (rsp_hit),
  .rsp_value    (rsp_value),
  .trn_valid    (trn_valid),
  .trn_in_range (trn_in_range),
  .vld_q        (vld_q),
  .lk_hit_oh    (lk_hit_oh),
  .tr_hit_oh    (tr_hit_oh)
);

// File: tb/avd_predictor_tb.sv
`timescale 1ns/1ps
module avd_predictor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trn_valid = 1'b0;
  logic        trn_ready;
  logic [31:0] trn_pc = '0, trn_addr = '0, trn_data = '0;
  logic        lkp_valid = 1'b0;
  logic        lkp_ready;
  logic [31:0] lkp_pc = '0, lkp_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic [31:0] rsp_value;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bit          exp_hit_q [$];
  logic [31:0] exp_val_q [$];
  string       exp_req_q [$];

  always #2.5 clk = ~clk;

  avd_predictor u_dut (
    .clk(clk), .rst_n(rst_n),
    .trn_valid(trn_valid), .trn_ready(trn_ready), .trn_pc(trn_pc),
    .trn_addr(trn_addr), .trn_data(trn_data),
    .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_pc(lkp_pc), .lkp_addr(lkp_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_value(rsp_value)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic train(input logic [31:0] pc, input logic [31:0] addr, input logic [31:0] data);
    @(posedge clk); #1;
    trn_valid = 1'b1; trn_pc = pc; trn_addr = addr; trn_data = data;
    @(posedge clk); #1;
    trn_valid = 1'b0;
  endtask

  task automatic train_n(input logic [31:0] pc, input logic [31:0] addr,
                         input logic [31:0] data, input int n);
    for (int i = 0; i < n; i++) train(pc, addr, data);
  endtask

  task automatic lookup(input logic [31:0] pc, input logic [31:0] addr,
                        input bit eh, input logic [31:0] ev, input string req);
    @(posedge clk); #1;
    lkp_valid = 1'b1; lkp_pc = pc; lkp_addr = addr;
    exp_hit_q.push_back(eh); exp_val_q.push_back(ev); exp_req_q.push_back(req);
    @(posedge clk); #1;
    lkp_valid = 1'b0;
  endtask

  // monitor: mid-cycle sample of a response that is taken at the next edge
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_hit_q.size() == 0) begin
        check(1'b0, "R8", "unexpected response", 32'(rsp_hit), 32'(0));
      end else begin
        automatic bit          eh = exp_hit_q.pop_front();
        automatic logic [31:0] ev = exp_val_q.pop_front();
        automatic string       rq = exp_req_q.pop_front();
        check(rsp_hit == eh, rq, "rsp_hit", 32'(rsp_hit), 32'(eh));
        check(rsp_value == ev, rq, "rsp_value", rsp_value, ev);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=%h exp=%h", 32'(0), 32'(1));
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rsp_valid == 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 32'(0));
    check(lkp_ready == 1'b1, "R1", "lkp_ready", 32'(lkp_ready), 32'(1));
    check(trn_ready == 1'b1, "R1", "trn_ready", 32'(trn_ready), 32'(1));
    lookup(32'h100, 32'h1234, 1'b0, 32'h0, "R1/R10 empty table");

    // R3/R4: delta 0x100 at pc A (set 0)
    train(32'h1000, 32'h8000, 32'h7F00);
    lookup(32'h1000, 32'h9000, 1'b0, 32'h0, "R3 after one training");
    train(32'h1000, 32'h8000, 32'h7F00);
    lookup(32'h1000, 32'h9000, 1'b0, 32'h0, "R4 conf 1");
    train(32'h1000, 32'h8000, 32'h7F00);
    lookup(32'h1000, 32'h9000, 1'b1, 32'h8F00, "R4 conf 2");
    train_n(32'h1000, 32'h8100, 32'h8000, 3);
    lookup(32'h1000, 32'h9000, 1'b1, 32'h8F00, "R4 saturated");

    // R5: new delta 0x80 clears confidence
    train(32'h1000, 32'h8000, 32'h7F80);
    lookup(32'h1000, 32'h9000, 1'b0, 32'h0, "R5 delta replaced");
    train_n(32'h1000, 32'h8000, 32'h7F80, 2);
    lookup(32'h1000, 32'h9000, 1'b1, 32'h8F80, "R5 new delta learned");
    // R6 wrap below zero
    lookup(32'h1000, 32'h40, 1'b1, 32'hFFFF_FFC0, "R6 wrap");

    // R2: boundary -1024 and +1024 trained, +1025 dropped
    train_n(32'h2008, 32'h2000, 32'h2400, 3);
    lookup(32'h2008, 32'h3000, 1'b1, 32'h3400, "R2/R6 delta -MAX");
    train_n(32'h400C, 32'h2400, 32'h2000, 3);
    lookup(32'h400C, 32'h3000, 1'b1, 32'h2C00, "R2 delta +MAX");
    train_n(32'h300C, 32'h2401, 32'h2000, 3);
    lookup(32'h300C, 32'h3000, 1'b0, 32'h0, "R2 delta MAX+1 dropped");
    train(32'h2008, 32'h9000, 32'h1000);
    lookup(32'h2008, 32'h3000, 1'b1, 32'h3400, "R2 dropped load leaves entry");

    // R7: replacement order in set 1
    train_n(32'h104, 32'h1000, 32'h0F00, 3);
    train_n(32'h114, 32'h1000, 32'h0F00, 3);
    train_n(32'h124, 32'h1000, 32'h0F00, 3);
    train_n(32'h134, 32'h1000, 32'h0F00, 3);
    train(32'h114, 32'h1000, 32'h0F00);
    train(32'h144, 32'h1000, 32'h0F00);
    lookup(32'h104, 32'h5000, 1'b0, 32'h0, "R7 oldest evicted");
    lookup(32'h114, 32'h5000, 1'b1, 32'h4F00, "R7 retouched kept");
    lookup(32'h134, 32'h5000, 1'b1, 32'h4F00, "R7 kept");
    lookup(32'h124, 32'h5000, 1'b1, 32'h4F00, "R7 kept");
    lookup(32'h144, 32'h5000, 1'b0, 32'h0, "R7 new entry conf 0");
    train(32'h154, 32'h1000, 32'h0F00);
    lookup(32'h124, 32'h5000, 1'b0, 32'h0, "R7 lookups do not refresh");
    lookup(32'h134, 32'h5000, 1'b1, 32'h4F00, "R7 kept after second eviction");
    lookup(32'h1000, 32'h9000, 1'b1, 32'h8F80, "R7 other set untouched");

    // R9: same-cycle training and lookup
    train_n(32'h5008, 32'h6000, 32'h5F00, 2);
    @(posedge clk); #1;
    trn_valid = 1'b1; trn_pc = 32'h5008; trn_addr = 32'h6000; trn_data = 32'h5F00;
    lkp_valid = 1'b1; lkp_pc = 32'h5008; lkp_addr = 32'h7000;
    exp_hit_q.push_back(1'b0); exp_val_q.push_back(32'h0); exp_req_q.push_back("R9 pre-training view");
    @(posedge clk); #1;
    trn_valid = 1'b0; lkp_valid = 1'b0;
    lookup(32'h5008, 32'h7000, 1'b1, 32'h6F00, "R9 after training");

    // R8: back-pressure
    @(posedge clk); #1;
    rsp_ready = 1'b0;
    lkp_valid = 1'b1; lkp_pc = 32'h1000; lkp_addr = 32'hA000;
    exp_hit_q.push_back(1'b1); exp_val_q.push_back(32'h9F80); exp_req_q.push_back("R8 held response");
    @(posedge clk); #1;
    lkp_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(lkp_ready == 1'b0, "R8", "lkp_ready during stall", 32'(lkp_ready), 32'(0));
    check(rsp_valid == 1'b1, "R8", "rsp_valid during stall", 32'(rsp_valid), 32'(1));
    check(rsp_value == 32'h9F80, "R8", "rsp_value during stall", rsp_value, 32'h9F80);
    @(posedge clk); #1;
    rsp_ready = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R8", "rsp_valid after take", 32'(rsp_valid), 32'(0));

    repeat (3) @(posedge clk);
    check(exp_hit_q.size() == 0, "R8", "responses missing", 32'(exp_hit_q.size()), 32'(0));
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule